// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a CPU with a 16-bit address bus and the memories behind it: cartridge ROM (up to 4 MiB), up to two 16 KiB banks of cartridge RAM, and a small system RAM. The logical space is cut into four 16 KiB windows. Address bits 15:14 pick a window, and bits 13:0 are the offset inside it. Each window is steered to a physical memory and page by paging registers. These registers are loaded by watching the CPU's own write cycles. No separate register port exists.

A static strap chooses one of two register schemes. In the **high-register** scheme, the top four addresses of the space hold the three page registers and a RAM control byte. In the **slot-base** scheme, a write to the first byte of windows 0, 1 or 2 sets that window's page. The translation is purely combinational. Register updates land on the clock edge of the write, so the write itself is routed with the mapping in force before it. The memories themselves are outside the block.

Top module: `bank_mapper`

## Requirements
- R1: Address bits 15:14 select a window and bits 13:0 pass unchanged as the low 14 bits of the physical address. For a ROM-mapped window, physical bits 21:14 carry the window's effective page. Target encoding: 2'b00 ROM, 2'b01 cartridge RAM, 2'b10 system RAM.
- R2: In high-register mode, logical 0x0000 to 0x03FF always map to ROM page 0, whatever page window 0 holds. The rest of window 0 follows its page register. In slot-base mode no such fixed region exists.
- R3: In high-register mode, writes to 0xFFFD, 0xFFFE and 0xFFFF load the page registers of windows 0, 1 and 2.
- R4: In high-register mode, a write to 0xFFFC sets the RAM control:
  - bit 3 puts cartridge RAM in window 2, and bit 2 picks bank 1 there instead of bank 0;
  - bit 4 puts cartridge RAM bank 0 in window 3 instead of system RAM;
  - the window-2 page register is kept, so clearing bit 3 restores ROM at that page;
  - writing 0xFFFF while RAM is in window 2 keeps RAM there.
  
  The cartridge RAM physical address is bank*0x4000 + offset.
- R5: The ROM page used for translation is the held page number modulo the ROM page count input. A count of 0 is treated as 1.
- R6: In slot-base mode, writes to 0x0000, 0x4000 and 0x8000 load the pages of windows 0, 1 and 2. Window 3 is always system RAM. Writes to 0xFFFC through 0xFFFF change no mapping.
- R7: After reset, window 3 is system RAM and the RAM control is clear. In high-register mode windows 0, 1 and 2 hold pages 0, 1 and 2. In slot-base mode they hold pages 0, 1 and 0.
- R8: System RAM is 8 KiB and is mirrored across window 3: the physical address is the offset modulo 0x2000.
- R9: The memory write enable is high only for a CPU write whose target is not ROM. A register write is also passed through to the memory mapped at its address, using the mapping before the write.
- R10: The mapping changes only on the clock edge of a CPU write. The new mapping applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_hi | input | 1 | Static strap: 1 selects the high-register scheme, 0 the slot-base scheme |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| rom_pages | input | 9 | ROM size as a count of 16 KiB pages |
| phys_addr | output | 22 | Physical address within the selected memory |
| target | output | 2 | Selected memory: 00 ROM, 01 cartridge RAM, 10 system RAM |
| mem_we | output | 1 | Write enable toward the selected memory |

## Verification
The assertions check four properties on every cycle:
- the fixed first kilobyte of window 0;
- that ROM pages never reach the page count;
- the system RAM mirror, and that window 3 stays on system RAM in slot-base mode;
- that the translation holds still when no write occurred.

Only the bench's scenarios can show which register each address loads, how the control bits steer windows 2 and 3, the reset mapping in each mode, and that a write uses the old mapping. These depend on ordered write sequences and on expected physical addresses computed by hand.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int PAGE_W       = 8,
  parameter int OFF_W        = 14,
  parameter int SYSRAM_BYTES = 8192,
  parameter int FIXED_BYTES  = 1024,
  parameter int ROM_AW       = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_hi,
  input  logic [OFF_W+1:0]  cpu_addr,
  input  logic [PAGE_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [PAGE_W:0]   rom_pages,
  output logic [ROM_AW-1:0] phys_addr,
  output logic [1:0]        target,
  output logic              mem_we
);
  localparam int AW    = OFF_W + 2;
  localparam int SYS_W = $clog2(SYSRAM_BYTES);
  localparam int FIX_W = $clog2(FIXED_BYTES);
  localparam logic [AW-1:0] A_CTRL = {AW{1'b1}} - AW'(3);
  localparam logic [AW-1:0] A_PG0  = {AW{1'b1}} - AW'(2);
  localparam logic [AW-1:0] A_PG1  = {AW{1'b1}} - AW'(1);
  localparam logic [AW-1:0] A_PG2  = {AW{1'b1}};
  localparam logic [1:0] T_ROM = 2'd0, T_CRAM = 2'd1, T_SYS = 2'd2;

  logic [PAGE_W-1:0] pg0, pg1, pg2;
  logic ram2_on, ram2_bank, ram3_on;

  wire [1:0]       slot = cpu_addr[AW-1:OFF_W];
  wire [OFF_W-1:0] off  = cpu_addr[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg0       <= '0;
      pg1       <= PAGE_W'(1);
      pg2       <= mode_hi ? PAGE_W'(2) : '0;
      ram2_on   <= 1'b0;
      ram2_bank <= 1'b0;
      ram3_on   <= 1'b0;
    end else if (cpu_we) begin
      if (mode_hi) begin
        case (cpu_addr)
          A_CTRL: begin
            ram2_on   <= cpu_wdata[3];
            ram2_bank <= cpu_wdata[2];
            ram3_on   <= cpu_wdata[4];
          end
          A_PG0:   pg0 <= cpu_wdata;
          A_PG1:   pg1 <= cpu_wdata;
          A_PG2:   pg2 <= cpu_wdata;
          default: ;
        endcase
      end else if (off == '0) begin
        case (slot)
          2'd0:    pg0 <= cpu_wdata;
          2'd1:    pg1 <= cpu_wdata;
          2'd2:    pg2 <= cpu_wdata;
          default: ;
        endcase
      end
    end
  end

  logic [PAGE_W-1:0] raw_pg, eff_pg;
  wire  [PAGE_W:0]   divisor = (rom_pages == '0) ? (PAGE_W+1)'(1) : rom_pages;
  wire               fixed   = mode_hi && slot == 2'd0 && off[OFF_W-1:FIX_W] == '0;

  assign raw_pg = (slot == 2'd0) ? pg0 : (slot == 2'd1) ? pg1 : pg2;
  assign eff_pg = PAGE_W'({1'b0, raw_pg} % divisor);

  always_comb begin
    target    = T_ROM;
    phys_addr = {fixed ? {PAGE_W{1'b0}} : eff_pg, off};
    if (slot == 2'd2 && mode_hi && ram2_on) begin
      target    = T_CRAM;
      phys_addr = ROM_AW'({ram2_bank, off});
    end
    if (slot == 2'd3) begin
      if (mode_hi && ram3_on) begin
        target    = T_CRAM;
        phys_addr = ROM_AW'(off);
      end else begin
        target    = T_SYS;
        phys_addr = ROM_AW'(off[SYS_W-1:0]);
      end
    end
  end

  assign mem_we = cpu_we && target != T_ROM;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int PAGE_W       = 8,
  parameter int OFF_W        = 14,
  parameter int SYSRAM_BYTES = 8192,
  parameter int FIXED_BYTES  = 1024,
  parameter int ROM_AW       = PAGE_W + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_hi,
  input logic [OFF_W+1:0]  cpu_addr,
  input logic [PAGE_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic [PAGE_W:0]   rom_pages,
  input logic [ROM_AW-1:0] phys_addr,
  input logic [1:0]        target,
  input logic              mem_we
);
  localparam int SYS_W = $clog2(SYSRAM_BYTES);
  localparam int FIX_W = $clog2(FIXED_BYTES);

  p_fixed_kib_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && cpu_addr[OFF_W+1:FIX_W] == '0) |->
      (target == 2'd0 && phys_addr[ROM_AW-1:OFF_W] == '0 && phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

  p_page_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (target == 2'd0 && rom_pages != '0) |-> ({1'b0, phys_addr[ROM_AW-1:OFF_W]} < rom_pages));

  p_sys_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (target == 2'd2) |-> (phys_addr[ROM_AW-1:SYS_W] == '0 && phys_addr[SYS_W-1:0] == cpu_addr[SYS_W-1:0]));

  p_slot3_sys_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && cpu_addr[OFF_W+1:OFF_W] == 2'd3) |-> (target == 2'd2));

  p_hold_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cpu_we) && $stable(cpu_addr) && $stable(mode_hi) && $stable(rom_pages)) |->
      ($stable(phys_addr) && $stable(target)));

  p_rom_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_we) |-> !mem_we);
endmodule

bind bank_mapper bank_mapper_chk #(
  .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SYSRAM_BYTES(SYSRAM_BYTES),
  .FIXED_BYTES(FIXED_BYTES), .ROM_AW(ROM_AW)
) i_chk (.*);

// File: tb/test_bank_mapper.sv
`timescale 1ns/1ps
module test_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_hi = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [8:0]  rom_pages = 9'd8;
  logic [21:0] phys_addr;
  logic [1:0]  target;
  logic        mem_we;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bank_mapper i_bank_mapper (
    .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .rom_pages(rom_pages),
    .phys_addr(phys_addr), .target(target), .mem_we(mem_we)
  );

  // {we, addr, data, target, phys, mem_we}; high-register mode, 8 ROM pages
  localparam int NV = 26;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 16'h4123, 8'h00, 2'd0, 22'h004123, 1'b0},
    {1'b0, 16'h8010, 8'h00, 2'd0, 22'h008010, 1'b0},
    {1'b0, 16'hC005, 8'h00, 2'd2, 22'h000005, 1'b0},
    {1'b0, 16'hE005, 8'h00, 2'd2, 22'h000005, 1'b0},
    {1'b1, 16'hFFFE, 8'h05, 2'd2, 22'h001FFE, 1'b1},
    {1'b0, 16'h4123, 8'h00, 2'd0, 22'h014123, 1'b0},
    {1'b1, 16'hFFFD, 8'h03, 2'd2, 22'h001FFD, 1'b1},
    {1'b0, 16'h0200, 8'h00, 2'd0, 22'h000200, 1'b0},
    {1'b0, 16'h0400, 8'h00, 2'd0, 22'h00C400, 1'b0},
    {1'b1, 16'hFFFF, 8'h0B, 2'd2, 22'h001FFF, 1'b1},
    {1'b0, 16'h8000, 8'h00, 2'd0, 22'h00C000, 1'b0},
    {1'b1, 16'hFFFC, 8'h18, 2'd2, 22'h001FFC, 1'b1},
    {1'b0, 16'h8123, 8'h00, 2'd1, 22'h000123, 1'b0},
    {1'b1, 16'h8123, 8'hAA, 2'd1, 22'h000123, 1'b1},
    {1'b0, 16'hC042, 8'h00, 2'd1, 22'h000042, 1'b0},
    {1'b1, 16'hFFFF, 8'h06, 2'd1, 22'h003FFF, 1'b1},
    {1'b0, 16'h8001, 8'h00, 2'd1, 22'h000001, 1'b0},
    {1'b1, 16'hFFFC, 8'h0C, 2'd1, 22'h003FFC, 1'b1},
    {1'b0, 16'h8001, 8'h00, 2'd1, 22'h004001, 1'b0},
    {1'b0, 16'hC001, 8'h00, 2'd2, 22'h000001, 1'b0},
    {1'b1, 16'hFFFC, 8'h00, 2'd2, 22'h001FFC, 1'b1},
    {1'b0, 16'h8001, 8'h00, 2'd0, 22'h018001, 1'b0},
    {1'b1, 16'h4000, 8'h02, 2'd0, 22'h014000, 1'b0},
    {1'b0, 16'h4000, 8'h00, 2'd0, 22'h014000, 1'b0},
    {1'b1, 16'h0000, 8'h01, 2'd0, 22'h000000, 1'b0},
    {1'b0, 16'h0800, 8'h00, 2'd0, 22'h00C800, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 2:                        return "R1";
      3:                              return "R8";
      5:                              return "R10";
      6, 8:                           return "R3";
      7, 25:                          return "R2";
      10:                             return "R5";
      12, 14, 16, 18, 19, 21:         return "R4";
      default:                        return "R9";
    endcase
  endfunction

  task automatic step(input logic we, input logic [15:0] a, input logic [7:0] d,
                      input logic [1:0] et, input logic [21:0] ep, input logic ew,
                      input string tag);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    n_run++;
    if (target !== et || phys_addr !== ep || mem_we !== ew) begin
      n_fail++;
      $display("FAIL %s addr=%h: got tgt=%0d phys=%h we=%b, expected tgt=%0d phys=%h we=%b",
               tag, a, target, phys_addr, mem_we, et, ep, ew);
    end
  endtask

  task automatic restart(input logic hi, input logic [8:0] pages);
    @(negedge clk);
    rst_n = 1'b0; cpu_we = 1'b0; mode_hi = hi; rom_pages = pages;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    restart(1'b1, 9'd8);
    // R7: reset mapping, high-register mode
    step(0, 16'h0000, 0, 2'd0, 22'h000000, 0, "R7");
    step(0, 16'h4000, 0, 2'd0, 22'h004000, 0, "R7");
    step(0, 16'h8000, 0, 2'd0, 22'h008000, 0, "R7");
    step(0, 16'hC000, 0, 2'd2, 22'h000000, 0, "R7");
    for (int i = 0; i < NV; i++)
      step(VEC[i][49], VEC[i][48:33], VEC[i][32:25], VEC[i][24:23], VEC[i][22:1], VEC[i][0], vec_tag(i));

    // R5: modulo with a 3-page ROM
    restart(1'b1, 9'd3);
    step(0, 16'h8000, 0, 2'd0, 22'h008000, 0, "R5");
    step(1, 16'hFFFE, 8'h05, 2'd2, 22'h001FFE, 1, "R5");
    step(0, 16'h4010, 0, 2'd0, 22'h008010, 0, "R5");
    step(1, 16'hFFFD, 8'hFF, 2'd2, 22'h001FFD, 1, "R5");
    step(0, 16'h0400, 0, 2'd0, 22'h000400, 0, "R5");

    // R7 / R6: slot-base scheme
    restart(1'b0, 9'd8);
    step(0, 16'h0000, 0, 2'd0, 22'h000000, 0, "R7");
    step(0, 16'h4000, 0, 2'd0, 22'h004000, 0, "R7");
    step(0, 16'h8000, 0, 2'd0, 22'h000000, 0, "R7");
    step(1, 16'h8000, 8'h05, 2'd0, 22'h000000, 0, "R6");
    step(0, 16'h8010, 0, 2'd0, 22'h014010, 0, "R6");
    step(1, 16'h0000, 8'h03, 2'd0, 22'h000000, 0, "R6");
    step(0, 16'h0200, 0, 2'd0, 22'h00C200, 0, "R6");
    step(1, 16'h4000, 8'h0A, 2'd0, 22'h004000, 0, "R6");
    step(0, 16'h4000, 0, 2'd0, 22'h008000, 0, "R6");
    step(1, 16'hFFFC, 8'h18, 2'd2, 22'h001FFC, 1, "R6");
    step(0, 16'h8000, 0, 2'd0, 22'h014000, 0, "R6");
    step(0, 16'hC000, 0, 2'd2, 22'h000000, 0, "R6");
    step(1, 16'hFFFE, 8'h07, 2'd2, 22'h001FFE, 1, "R6");
    step(0, 16'h4000, 0, 2'd0, 22'h008000, 0, "R6");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule